// File: doc/BRIEF.md
# MIDI Host Port Slave

This block sits between a legacy ISA-style I/O bus and a MIDI processing core. A host program talks to it through two byte-wide I/O locations. The lower one carries data in both directions. The upper one accepts command bytes when written and returns a status byte when read. The host side has no clock of its own: the read and write strobes arrive asynchronously, and write data is latched on the trailing edge of the write strobe. Each completed access is then handed to the core clock domain through a toggle handshake.

The port answers in one of two ways. In the first, the full 10-bit host address is compared against one of four base pairs chosen by a 2-bit pin selection. In the second, an external chip select qualifies the access and only the low nibble of the address is decoded. The block drives an enable for an external bus transceiver whenever it is addressed, and it raises an interrupt while a byte for the host is waiting. The reset input can be active high or active low, as a polarity pin selects.

Toward the core, host writes appear in a one-entry buffer with a valid/ready handshake and a flag that marks command bytes. Bytes for the host are offered by the core with a valid/ready handshake. The block does not interpret host commands and does not touch any serial line.

Top module: `midi_host_port`

## Requirements
- R1: With `aen_n_i` low, the port is addressed exactly at addresses 0x320+0x10*`base_sel_i` and that value +1. Selections 0..3 give 0x320, 0x330, 0x340 and 0x350. An access at any other address has no effect and produces no bus response.
- R2: With `cs_n_i` low, the port is addressed whenever `addr_i[3:1]` is 0, whatever the upper address bits are. With both `aen_n_i` and `cs_n_i` high, the port is never addressed. Address bit 0 selects the location: 0 is data, 1 is command/status.
- R3: `hd_drive_o` is high exactly while the port is addressed and `rd_n_i` is low. `buf_en_n_o` is low exactly while the port is addressed and either strobe is low.
- R4: A write to an addressed location is captured on the rising edge of `wr_n_i`. It appears as `hb_valid_o`=1 with `hb_data_o` and `hb_is_cmd_o` (0 for data, 1 for command) on the third core clock edge after that rising edge. It then holds until a cycle with `hb_ready_i` high.
- R5: A status read returns bit 7 = 0 when a byte for the host is waiting, bit 6 = 0 when the host-write buffer is empty, and bits 5..0 = 1.
- R6: `out_ready_o` is high while no byte for the host is waiting. A byte offered with `out_valid_i` at such an edge is stored and returned by host reads of the data location.
- R7: The rising edge of `rd_n_i` on an addressed data-location read clears the waiting byte on the third core clock edge after it. Status reads leave it waiting.
- R8: `irq_o` is high exactly while a byte for the host is waiting.
- R9: A host write that arrives while the buffer is full is discarded. If the core drains the buffer at the same clock edge as the arrival, the new byte is taken.
- R10: With `rst_pol_i` high, `rst_host_i` resets the block when high. With `rst_pol_i` low, it resets the block when low. Reset empties the buffer, drops `irq_o` and raises `out_ready_o`.
- R11: A write to an unaddressed location changes no state seen by the core or the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_host_i | input | 1 | Host reset, sense chosen by rst_pol_i |
| rst_pol_i | input | 1 | 1: reset active high, 0: reset active low |
| addr_i | input | ADDR_W | Host I/O address |
| aen_n_i | input | 1 | Active-low enable of full address decode |
| cs_n_i | input | 1 | Active-low external chip select |
| base_sel_i | input | 2 | Base range selection |
| rd_n_i | input | 1 | Active-low host read strobe |
| wr_n_i | input | 1 | Active-low host write strobe |
| hd_i | input | DATA_W | Host write data |
| hd_o | output | DATA_W | Host read data |
| hd_drive_o | output | 1 | Host data bus drive enable |
| buf_en_n_o | output | 1 | Active-low external transceiver enable |
| irq_o | output | 1 | Active-high host interrupt |
| hb_data_o | output | DATA_W | Byte written by the host |
| hb_is_cmd_o | output | 1 | Byte came through the command location |
| hb_valid_o | output | 1 | Host byte available to core |
| hb_ready_i | input | 1 | Core takes the host byte |
| out_data_i | input | DATA_W | Byte from core to host |
| out_valid_i | input | 1 | Core offers a byte |
| out_ready_o | output | 1 | Block can accept a byte for the host |

## Verification
Two functions can land on the same core clock edge. One is a host write emerging from the synchronizer. The other is the core draining the one-entry buffer. The bench provokes this by writing into a full buffer and raising `hb_ready_i` so that the drain falls on the third edge after the strobe rises. It then judges that the new byte, not the old one, is presented. A second overlap pairs the clearing of a waiting byte with a held core offer: the offer must be taken only on the edge after the clear, never lost.

// File: rtl/mhp_pkg.sv
package mhp_pkg;
   localparam int MHP_ADDR_W    = 10;
   localparam int MHP_DATA_W    = 8;
   localparam int MHP_SEL_W     = 2;
   localparam int MHP_BASE_LO   = 'h320;
   localparam int MHP_BASE_STEP = 'h10;
   localparam int MHP_CS_W      = 4;
   localparam int MHP_SYNC_N    = 2;

   // location selected by address bit 0
   typedef enum logic {
      PORT_DATA = 1'b0,
      PORT_CTRL = 1'b1
   } mhp_port_e;
endpackage

// File: rtl/mhp_decode.sv
module mhp_decode #(
   parameter int ADDR_W    = mhp_pkg::MHP_ADDR_W,
   parameter int SEL_W     = mhp_pkg::MHP_SEL_W,
   parameter int BASE_LO   = mhp_pkg::MHP_BASE_LO,
   parameter int BASE_STEP = mhp_pkg::MHP_BASE_STEP,
   parameter int CS_W      = mhp_pkg::MHP_CS_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              aen_n_i,
   input  logic              cs_n_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              hit_o,
   output mhp_pkg::mhp_port_e port_o
);
   localparam int NUM_BASES = 1 << SEL_W;

   if (CS_W < 2 || CS_W > ADDR_W) begin : g_bad_cs
      $error("mhp_decode: CS_W out of range");
   end
   if ((BASE_LO % 2) != 0 || (BASE_STEP % 2) != 0) begin : g_bad_base
      $error("mhp_decode: base and step must be even");
   end

   logic [NUM_BASES-1:0] base_match;

   for (genvar b = 0; b < NUM_BASES; b++) begin : g_base
      localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(BASE_LO + b * BASE_STEP);
      assign base_match[b] = (addr_i[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
   end

   logic full_hit;
   logic cs_hit;

   always_comb begin
      full_hit = !aen_n_i && base_match[sel_i];
      cs_hit   = !cs_n_i && (addr_i[CS_W-1:1] == '0);
      hit_o    = full_hit || cs_hit;
      port_o   = mhp_pkg::mhp_port_e'(addr_i[0]);
   end
endmodule

// File: rtl/mhp_host_cap.sv
module mhp_host_cap #(
   parameter int DATA_W = mhp_pkg::MHP_DATA_W
) (
   input  logic              rst_i,
   input  logic              wr_n_i,
   input  logic              rd_n_i,
   input  logic              hit_i,
   input  mhp_pkg::mhp_port_e port_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              wr_tgl_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              wr_cmd_o,
   output logic              rd_tgl_o
);
   import mhp_pkg::*;

   // host write strobe domain: latch on trailing edge
   always_ff @(posedge wr_n_i or posedge rst_i) begin
      if (rst_i) begin
         wr_tgl_o  <= 1'b0;
         wr_data_o <= '0;
         wr_cmd_o  <= 1'b0;
      end else if (hit_i) begin
         wr_data_o <= data_i;
         wr_cmd_o  <= (port_i == PORT_CTRL);
         wr_tgl_o  <= ~wr_tgl_o;
      end
   end

   // host read strobe domain: note completed data-location reads
   always_ff @(posedge rd_n_i or posedge rst_i) begin
      if (rst_i) begin
         rd_tgl_o <= 1'b0;
      end else if (hit_i && port_i == PORT_DATA) begin
         rd_tgl_o <= ~rd_tgl_o;
      end
   end
endmodule

// File: rtl/mhp_tgl_sync.sv
module mhp_tgl_sync #(
   parameter int STAGES = mhp_pkg::MHP_SYNC_N
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic tgl_i,
   output logic pulse_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mhp_tgl_sync: at least two stages required");
   end

   logic [STAGES-1:0] chain;
   logic              seen;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain[0] <= 1'b0;
            else       chain[0] <= tgl_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) chain[s] <= 1'b0;
            else       chain[s] <= chain[s-1];
         end
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) seen <= 1'b0;
      else       seen <= chain[STAGES-1];
   end

   assign pulse_o = chain[STAGES-1] ^ seen;
endmodule

// File: rtl/mhp_core_regs.sv
module mhp_core_regs #(
   parameter int DATA_W = mhp_pkg::MHP_DATA_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_pulse_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_cmd_i,
   input  logic              rd_pulse_i,
   input  logic              hb_ready_i,
   input  logic              out_valid_i,
   input  logic [DATA_W-1:0] out_data_i,
   output logic              hb_valid_o,
   output logic [DATA_W-1:0] hb_data_o,
   output logic              hb_is_cmd_o,
   output logic              rx_avail_o,
   output logic [DATA_W-1:0] rx_data_o
);
   logic drain;
   logic take;
   logic accept;

   always_comb begin
      drain  = hb_valid_o && hb_ready_i;
      take   = wr_pulse_i && (!hb_valid_o || drain);
      accept = out_valid_i && !rx_avail_o;
   end

   // host -> core one-entry buffer
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         hb_valid_o  <= 1'b0;
         hb_data_o   <= '0;
         hb_is_cmd_o <= 1'b0;
      end else if (take) begin
         hb_valid_o  <= 1'b1;
         hb_data_o   <= wr_data_i;
         hb_is_cmd_o <= wr_cmd_i;
      end else if (drain) begin
         hb_valid_o  <= 1'b0;
      end
   end

   // core -> host holding register; a load outranks a stale clear
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         rx_avail_o <= 1'b0;
         rx_data_o  <= '0;
      end else if (accept) begin
         rx_avail_o <= 1'b1;
         rx_data_o  <= out_data_i;
      end else if (rd_pulse_i) begin
         rx_avail_o <= 1'b0;
      end
   end
endmodule

// File: rtl/midi_host_port.sv
module midi_host_port #(
   parameter int ADDR_W      = mhp_pkg::MHP_ADDR_W,
   parameter int DATA_W      = mhp_pkg::MHP_DATA_W,
   parameter int BASE_LO     = mhp_pkg::MHP_BASE_LO,
   parameter int BASE_STEP   = mhp_pkg::MHP_BASE_STEP,
   parameter int CS_W        = mhp_pkg::MHP_CS_W,
   parameter int SYNC_STAGES = mhp_pkg::MHP_SYNC_N
) (
   input  logic              clk_i,
   input  logic              rst_host_i,
   input  logic              rst_pol_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              aen_n_i,
   input  logic              cs_n_i,
   input  logic [1:0]        base_sel_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   input  logic [DATA_W-1:0] hd_i,
   output logic [DATA_W-1:0] hd_o,
   output logic              hd_drive_o,
   output logic              buf_en_n_o,
   output logic              irq_o,
   output logic [DATA_W-1:0] hb_data_o,
   output logic              hb_is_cmd_o,
   output logic              hb_valid_o,
   input  logic              hb_ready_i,
   input  logic [DATA_W-1:0] out_data_i,
   input  logic              out_valid_i,
   output logic              out_ready_o
);
   import mhp_pkg::*;

   localparam int FILL_W = DATA_W - 2;

   if (DATA_W < 3) begin : g_bad_data
      $error("midi_host_port: DATA_W must leave room for the ready flags");
   end

   logic              rst;
   logic              hit;
   mhp_port_e         port;
   logic              wr_tgl;
   logic              rd_tgl;
   logic [DATA_W-1:0] cap_data;
   logic              cap_cmd;
   logic              wr_pulse;
   logic              rd_pulse;
   logic              rx_avail;
   logic [DATA_W-1:0] rx_data;
   logic [DATA_W-1:0] status;

   assign rst = rst_pol_i ? rst_host_i : ~rst_host_i;

   mhp_decode #(
      .ADDR_W(ADDR_W), .SEL_W(2), .BASE_LO(BASE_LO),
      .BASE_STEP(BASE_STEP), .CS_W(CS_W)
   ) u_decode (
      .addr_i(addr_i), .aen_n_i(aen_n_i), .cs_n_i(cs_n_i),
      .sel_i(base_sel_i), .hit_o(hit), .port_o(port)
   );

   mhp_host_cap #(.DATA_W(DATA_W)) u_cap (
      .rst_i(rst), .wr_n_i(wr_n_i), .rd_n_i(rd_n_i), .hit_i(hit),
      .port_i(port), .data_i(hd_i), .wr_tgl_o(wr_tgl),
      .wr_data_o(cap_data), .wr_cmd_o(cap_cmd), .rd_tgl_o(rd_tgl)
   );

   mhp_tgl_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk_i(clk_i), .rst_i(rst), .tgl_i(wr_tgl), .pulse_o(wr_pulse)
   );

   mhp_tgl_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk_i(clk_i), .rst_i(rst), .tgl_i(rd_tgl), .pulse_o(rd_pulse)
   );

   mhp_core_regs #(.DATA_W(DATA_W)) u_regs (
      .clk_i(clk_i), .rst_i(rst),
      .wr_pulse_i(wr_pulse), .wr_data_i(cap_data), .wr_cmd_i(cap_cmd),
      .rd_pulse_i(rd_pulse), .hb_ready_i(hb_ready_i),
      .out_valid_i(out_valid_i), .out_data_i(out_data_i),
      .hb_valid_o(hb_valid_o), .hb_data_o(hb_data_o),
      .hb_is_cmd_o(hb_is_cmd_o), .rx_avail_o(rx_avail), .rx_data_o(rx_data)
   );

   // ready flags are active low, filler bits read as ones
   always_comb begin
      status     = {~rx_avail, hb_valid_o, {FILL_W{1'b1}}};
      hd_o       = (port == PORT_CTRL) ? status : rx_data;
      hd_drive_o = hit && !rd_n_i;
      buf_en_n_o = !(hit && (!rd_n_i || !wr_n_i));
      irq_o      = rx_avail;
      out_ready_o = !rx_avail;
   end
endmodule

// File: rtl/mhp_checker.sv
module mhp_checker #(
   parameter int DATA_W = mhp_pkg::MHP_DATA_W
) (
   input logic              clk_i,
   input logic              rst_host_i,
   input logic              rst_pol_i,
   input logic              port_sel_i,
   input logic [DATA_W-1:0] hd_o,
   input logic              hd_drive_o,
   input logic              buf_en_n_o,
   input logic              irq_o,
   input logic [DATA_W-1:0] hb_data_o,
   input logic              hb_is_cmd_o,
   input logic              hb_valid_o,
   input logic              hb_ready_i,
   input logic              out_valid_i,
   input logic              out_ready_o
);
   logic rst_act;
   assign rst_act = rst_pol_i ? rst_host_i : ~rst_host_i;

   // held host byte must not move until taken
   assert_hold_R4: assert property (@(posedge clk_i) disable iff (rst_act)
      hb_valid_o && !hb_ready_i |=> hb_valid_o && $stable(hb_data_o) && $stable(hb_is_cmd_o))
      else $error("host byte changed while not taken");

   assert_status_fill_R5: assert property (@(posedge clk_i) disable iff (rst_act)
      hd_drive_o && port_sel_i |-> (&hd_o[DATA_W-3:0]))
      else $error("status filler bits not all ones");

   assert_accept_closes_R6: assert property (@(posedge clk_i) disable iff (rst_act)
      out_valid_i && out_ready_o |=> !out_ready_o)
      else $error("ready stayed high after accepting a byte");

   assert_irq_source_R8: assert property (@(posedge clk_i) disable iff (rst_act)
      $rose(irq_o) |-> $past(out_valid_i && out_ready_o))
      else $error("interrupt rose without an accepted byte");

   assert_drive_enables_buf_R3: assert property (@(posedge clk_i) disable iff (rst_act)
      hd_drive_o |-> !buf_en_n_o)
      else $error("bus driven while transceiver disabled");

   always @(posedge clk_i) begin
      if (rst_act) begin
         assert_reset_clear_R10: assert (!hb_valid_o && !irq_o && out_ready_o)
            else $error("state not cleared under reset");
      end
   end
endmodule

bind midi_host_port mhp_checker #(.DATA_W(DATA_W)) u_mhp_checker (
   .clk_i(clk_i), .rst_host_i(rst_host_i), .rst_pol_i(rst_pol_i),
   .port_sel_i(addr_i[0]), .hd_o(hd_o), .hd_drive_o(hd_drive_o),
   .buf_en_n_o(buf_en_n_o), .irq_o(irq_o), .hb_data_o(hb_data_o),
   .hb_is_cmd_o(hb_is_cmd_o), .hb_valid_o(hb_valid_o),
   .hb_ready_i(hb_ready_i), .out_valid_i(out_valid_i),
   .out_ready_o(out_ready_o)
);

// File: tb/tb_midi_host_port.sv
module tb_midi_host_port;
   logic       clk = 1'b0;
   logic       rst_host, rst_pol;
   logic [9:0] addr;
   logic       aen_n, cs_n;
   logic [1:0] base_sel;
   logic       rd_n, wr_n;
   logic [7:0] hd_in, hd_out, hb_data, out_data;
   logic       hd_drive, buf_en_n, irq, hb_is_cmd, hb_valid, hb_ready;
   logic       out_valid, out_ready;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   midi_host_port dut (
      .clk_i(clk), .rst_host_i(rst_host), .rst_pol_i(rst_pol),
      .addr_i(addr), .aen_n_i(aen_n), .cs_n_i(cs_n), .base_sel_i(base_sel),
      .rd_n_i(rd_n), .wr_n_i(wr_n), .hd_i(hd_in), .hd_o(hd_out),
      .hd_drive_o(hd_drive), .buf_en_n_o(buf_en_n), .irq_o(irq),
      .hb_data_o(hb_data), .hb_is_cmd_o(hb_is_cmd), .hb_valid_o(hb_valid),
      .hb_ready_i(hb_ready), .out_data_i(out_data), .out_valid_i(out_valid),
      .out_ready_o(out_ready)
   );

   // ---------------- reference model ----------------
   logic       model_rst;
   assign model_rst = rst_pol ? rst_host : !rst_host;

   bit         m_tx_full, m_tx_cmd, m_rx_avail;
   bit [7:0]   m_tx_data, m_rx_data;
   int         m_wr_cnt, m_rd_cnt;
   bit [7:0]   m_wr_pd;
   bit         m_wr_pc;

   function automatic bit exp_hit(logic [9:0] a, logic aen, logic cs, logic [1:0] sel);
      int base;
      base = 'h320 + 'h10 * int'(sel);
      return (!aen && (int'(a) == base || int'(a) == base + 1)) ||
             (!cs && a[3:0] <= 4'd1);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit wr_ev, rd_ev, drain, accept;
      if (model_rst) begin
         m_tx_full = 0; m_tx_cmd = 0; m_tx_data = 0;
         m_rx_avail = 0; m_rx_data = 0;
         m_wr_cnt = 0; m_rd_cnt = 0;
      end else begin
         wr_ev = 0; rd_ev = 0;
         if (m_wr_cnt > 0) begin m_wr_cnt--; wr_ev = (m_wr_cnt == 0); end
         if (m_rd_cnt > 0) begin m_rd_cnt--; rd_ev = (m_rd_cnt == 0); end
         drain  = m_tx_full && hb_ready;
         accept = out_valid && !m_rx_avail;
         if (wr_ev && (!m_tx_full || drain)) begin
            m_tx_full = 1; m_tx_data = m_wr_pd; m_tx_cmd = m_wr_pc;
         end else if (drain) begin
            m_tx_full = 0;
         end
         if (accept) begin
            m_rx_avail = 1; m_rx_data = out_data;
         end else if (rd_ev) begin
            m_rx_avail = 0;
         end
      end
   end

   // per-clock comparison, away from the edge
   always @(posedge clk) begin
      bit h;
      #2;
      check("R4 hb_valid", hb_valid, m_tx_full);
      if (m_tx_full) check("R4 hb_is_cmd/hb_data", {hb_is_cmd, hb_data}, {m_tx_cmd, m_tx_data});
      check("R8 irq", irq, m_rx_avail);
      check("R6 out_ready", out_ready, !m_rx_avail);
      h = exp_hit(addr, aen_n, cs_n, base_sel);
      check("R3 hd_drive", hd_drive, h && !rd_n);
      check("R1 R2 buf_en_n", buf_en_n, !(h && (!rd_n || !wr_n)));
      if (h && !rd_n) begin
         if (addr[0]) check("R5 status", hd_out, {!m_rx_avail, m_tx_full, 6'h3F});
         else         check("R6 read data", hd_out, m_rx_data);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; hd_in = d; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      if (exp_hit(a, aen_n, cs_n, base_sel)) begin
         m_wr_cnt = 3; m_wr_pd = d; m_wr_pc = a[0];
      end
   endtask

   task automatic host_read(input logic [9:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; rd_n = 1'b0;
      #3 v = hd_out;
      @(negedge clk);
      rd_n = 1'b1;
      if (exp_hit(a, aen_n, cs_n, base_sel) && !a[0]) m_rd_cnt = 3;
   endtask

   task automatic pulse_ready();
      @(negedge clk); hb_ready = 1'b1;
      @(negedge clk); hb_ready = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [9:0] base;
      rst_pol = 1; rst_host = 1;
      addr = 0; aen_n = 1; cs_n = 1; base_sel = 0;
      rd_n = 1; wr_n = 1; hd_in = 0; hb_ready = 0; out_valid = 0; out_data = 0;
      idle(3);
      check("R10 reset hb_valid", hb_valid, 0);
      check("R10 reset irq", irq, 0);
      check("R10 reset out_ready", out_ready, 1);
      rst_host = 0;
      idle(2);

      // full-address decode over every base selection
      for (int s = 0; s < 4; s++) begin
         base_sel = 2'(s); aen_n = 0;
         base = 10'(('h320 + 'h10 * s));
         host_write(base, 8'(8'h40 + s)); idle(4);
         check("R4 data write valid", hb_valid, 1);
         check("R4 data write flag", hb_is_cmd, 0);
         check("R4 data write byte", hb_data, 8'h40 + s);
         pulse_ready();
         host_write(base + 10'd1, 8'(8'hF0 + s)); idle(4);
         check("R4 command write flag", hb_is_cmd, 1);
         check("R4 command write byte", hb_data, 8'hF0 + s);
         pulse_ready();
         host_write(base + 10'd2, 8'h77); idle(4);
         check("R11 write outside port", hb_valid, 0);
         host_write(10'(('h320 + 'h10 * ((s + 1) % 4))), 8'h78); idle(4);
         check("R1 other base ignored", hb_valid, 0);
         host_read(base + 10'd1, v);
         check("R5 idle status", v, 8'hBF);
      end

      // chip-select decode
      aen_n = 1; cs_n = 0;
      host_write(10'h3F1, 8'h5A); idle(4);
      check("R2 cs hit valid", hb_valid, 1);
      check("R2 cs hit command", {hb_is_cmd, hb_data}, {1'b1, 8'h5A});
      pulse_ready();
      host_write(10'h3F4, 8'h5B); idle(4);
      check("R2 cs low nibble miss", hb_valid, 0);
      cs_n = 1; base_sel = 0;
      host_write(10'h320, 8'h5C); idle(4);
      check("R2 no enable no hit", hb_valid, 0);
      aen_n = 0; base_sel = 1;

      // core to host path
      @(negedge clk); out_data = 8'hA5; out_valid = 1;
      @(negedge clk); out_data = 8'h3C;
      check("R6 ready drops", out_ready, 0);
      check("R8 irq raised", irq, 1);
      idle(3);
      host_read(10'h331, v);
      check("R5 byte waiting status", v, 8'h3F);
      idle(4);
      check("R7 status read keeps byte", irq, 1);
      host_read(10'h330, v);
      check("R6 read returns byte", v, 8'hA5);
      idle(3);
      check("R7 data read clears", irq, 0);
      idle(1);
      check("R6 held offer taken after clear", irq, 1);
      out_valid = 0;
      host_read(10'h330, v);
      check("R6 second byte", v, 8'h3C);
      idle(4);
      check("R7 cleared again", irq, 0);

      // overflow and same-edge drain
      host_write(10'h330, 8'h11); idle(4);
      host_write(10'h330, 8'h22); idle(4);
      check("R9 full buffer drops write", hb_data, 8'h11);
      host_write(10'h331, 8'h33);
      @(negedge clk);
      @(negedge clk); hb_ready = 1;
      @(negedge clk); hb_ready = 0;
      check("R9 same-edge drain keeps new byte", hb_valid, 1);
      check("R9 same-edge byte", {hb_is_cmd, hb_data}, {1'b1, 8'h33});
      pulse_ready();

      // active-low reset sense
      @(negedge clk); rst_pol = 0; rst_host = 1;
      host_write(10'h330, 8'h66);
      @(negedge clk); out_data = 8'h99; out_valid = 1;
      @(negedge clk); out_valid = 0;
      idle(3);
      check("R10 high level inactive", {hb_valid, irq}, 2'b11);
      @(negedge clk); rst_host = 0;
      idle(2);
      check("R10 low level resets buffer", hb_valid, 0);
      check("R10 low level resets irq", irq, 0);
      check("R10 low level ready", out_ready, 1);
      rst_host = 1;
      host_write(10'h330, 8'h12); idle(4);
      check("R10 works after reset", {hb_valid, hb_data}, {1'b1, 8'h12});
      pulse_ready();
      idle(3);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule